// File: doc/BRIEF.md
# Active-Window Video Cropper

The block sits in a video path and cuts a rectangular window out of each frame. It keeps the clock and the line and frame timing as they are. It receives a pixel stream with data-enable, horizontal sync, vertical sync and pixel data. Column and row positions count from the first active pixel of the first active line of the frame, not from the sync pulses. Inside the programmed window the data-enable passes through. Outside the window it is forced low. The pixels that are removed therefore become extra blanking, and the window may sit off-centre, so the two porches can end up unequal.

Four 16-bit coordinates set the window: first column, last column, first row and last row. Each is written as two byte registers through a simple write port. A separate enable bit chooses between cropping and plain pass-through. Values written at any time are held back and only take effect at the next rising edge of vertical sync. A frame is therefore always cropped with a single, consistent setting. Every output appears exactly one clock after the matching input.

Top module: `vid_crop`

## Requirements
- R1: `out_hs`, `out_vs` and `out_pix` equal `in_hs`, `in_vs` and `in_pix` from one clock earlier, whatever the crop setting.
- R2: During reset all outputs are low. After reset all coordinates are zero and cropping is disabled, so setting only the enable bit crops each frame to the single pixel at column 0, row 0.
- R3: With cropping disabled, `out_de` equals `in_de` delayed by one clock.
- R4: Column 0 is the pixel on which `in_de` rises. With cropping enabled, a pixel is kept only if its column lies between first and last column, both bounds included.
- R5: Row 0 is the first active line after a rising edge of `in_vs`. The row count advances on each falling edge of `in_de`. A pixel is kept only if its row lies between first and last row, both bounds included.
- R6: Register map at `wr_addr`: 0/1 first-column low/high byte, 2/3 last-column low/high, 4/5 first-row low/high, 6/7 last-row low/high, 8 bit 0 crop enable. Writes to addresses 9 to 15 have no effect.
- R7: Register writes take effect at the next rising edge of `in_vs`. A write made in the middle of a frame does not change the cropping of that frame.
- R8: If the first column is greater than the last column, or the first row is greater than the last row, no pixel of that frame is output.
- R9: `out_de` is never high unless `in_de` was high one clock earlier. The line length and frame height seen at the outputs are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write byte |
| in_de | input | 1 | Input data-enable |
| in_hs | input | 1 | Input horizontal sync |
| in_vs | input | 1 | Input vertical sync, active high |
| in_pix | input | DW | Input pixel data |
| out_de | output | 1 | Cropped data-enable |
| out_hs | output | 1 | Delayed horizontal sync |
| out_vs | output | 1 | Delayed vertical sync |
| out_pix | output | DW | Delayed pixel data |

## Verification
The hardest case to reach from the ports is a register write that lands in the middle of a frame. That frame must still be cropped with the old window, and the following frame with the new one. The stimulus reaches it by writing a complete new window into the horizontal blanking after the first active line, then running a second frame. Inverted windows, windows that touch the last column and last row, and writes to unused addresses are set up by directed frames. Random frame sizes and random windows, some of them inverted or reaching past the line, then cover the remaining mixes.

// File: rtl/vid_crop.sv
module vid_crop #(
  parameter int DW = 24,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          in_de,
  input  logic          in_hs,
  input  logic          in_vs,
  input  logic [DW-1:0] in_pix,
  output logic          out_de,
  output logic          out_hs,
  output logic          out_vs,
  output logic [DW-1:0] out_pix
);
  localparam int CW = 16;

  logic [CW-1:0] xs_r, xe_r, ys_r, ye_r;
  logic          en_r;
  logic [CW-1:0] xs_act, xe_act, ys_act, ye_act;
  logic          en_act;
  logic [CW-1:0] col_q, row_q;
  logic          de_q, vs_q;

  wire           vs_rise = in_vs & ~vs_q;
  wire           de_rise = in_de & ~de_q;
  wire           de_fall = ~in_de & de_q;
  wire [CW-1:0]  cur_col = de_rise ? '0 : col_q;
  wire           in_x    = (cur_col >= xs_act) && (cur_col <= xe_act);
  wire           in_y    = (row_q >= ys_act) && (row_q <= ye_act);
  wire           keep    = ~en_act | (in_x & in_y);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xs_r <= '0; xe_r <= '0; ys_r <= '0; ye_r <= '0; en_r <= 1'b0;
    end else if (wr_en) begin
      case (int'(wr_addr))
        0: xs_r[7:0]  <= wr_data;
        1: xs_r[15:8] <= wr_data;
        2: xe_r[7:0]  <= wr_data;
        3: xe_r[15:8] <= wr_data;
        4: ys_r[7:0]  <= wr_data;
        5: ys_r[15:8] <= wr_data;
        6: ye_r[7:0]  <= wr_data;
        7: ye_r[15:8] <= wr_data;
        8: en_r       <= wr_data[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xs_act <= '0; xe_act <= '0; ys_act <= '0; ye_act <= '0; en_act <= 1'b0;
    end else if (vs_rise) begin
      xs_act <= xs_r; xe_act <= xe_r; ys_act <= ys_r; ye_act <= ye_r; en_act <= en_r;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
      de_q  <= 1'b0;
      vs_q  <= 1'b0;
    end else begin
      de_q <= in_de;
      vs_q <= in_vs;
      if (in_de) col_q <= cur_col + 1'b1;
      if (vs_rise)      row_q <= '0;
      else if (de_fall) row_q <= row_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_de  <= 1'b0;
      out_hs  <= 1'b0;
      out_vs  <= 1'b0;
      out_pix <= '0;
    end else begin
      out_de  <= in_de & keep;
      out_hs  <= in_hs;
      out_vs  <= in_vs;
      out_pix <= in_pix;
    end
  end
endmodule

// File: rtl/vid_crop_chk.sv
module vid_crop_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_de,
  input logic        in_hs,
  input logic        in_vs,
  input logic        out_de,
  input logic        out_hs,
  input logic        out_vs,
  input logic        en_act,
  input logic [15:0] xs_act,
  input logic [15:0] xe_act,
  input logic [15:0] ys_act,
  input logic [15:0] ye_act
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;

  a_r1_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (out_hs == $past(in_hs)) && (out_vs == $past(in_vs)));

  a_r9_de_subset: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && out_de) |-> $past(in_de));

  a_r3_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(!en_act)) |-> (out_de == $past(in_de)));

  a_r8_inverted_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(en_act && ((xs_act > xe_act) || (ys_act > ye_act)))) |-> !out_de);

  a_r7_hold_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !(in_vs && !$past(in_vs))) |=> $stable({en_act, xs_act, xe_act, ys_act, ye_act}));
endmodule

bind vid_crop vid_crop_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_de(in_de), .in_hs(in_hs), .in_vs(in_vs),
  .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs), .en_act(en_act),
  .xs_act(xs_act), .xe_act(xe_act), .ys_act(ys_act), .ye_act(ye_act)
);

// File: tb/sim_vid_crop.sv
module sim_vid_crop;
  localparam int  DW    = 24;
  localparam time CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic in_de = 1'b0, in_hs = 1'b0, in_vs = 1'b0;
  logic [DW-1:0] in_pix = '0;
  logic out_de, out_hs, out_vs;
  logic [DW-1:0] out_pix;

  vid_crop #(.DW(DW), .AW(4)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .in_de(in_de), .in_hs(in_hs), .in_vs(in_vs), .in_pix(in_pix),
    .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs), .out_pix(out_pix));

  always #(CLK_P/2) clk = ~clk;

  int vectors = 0, miscompares = 0;
  bit done = 0;
  string tag = "R2";

  logic [7:0]  m_reg [0:8];
  logic [15:0] s_xs, s_xe, s_ys, s_ye;
  logic        s_en;
  logic [15:0] m_col, m_row;
  logic        m_de, m_vs;
  logic        have_exp = 0;
  logic        e_de, e_hs, e_vs;
  logic [DW-1:0] e_pix;

  function automatic logic keep_px(input logic [15:0] c, input logic [15:0] r);
    return !s_en || (c >= s_xs && c <= s_xe && r >= s_ys && r <= s_ye);
  endfunction

  task automatic step(input logic de, input logic hs, input logic vs,
                      input logic [DW-1:0] pix, input logic we,
                      input logic [3:0] wa, input logic [7:0] wd);
    logic [15:0] c;
    bit bad;
    @(negedge clk);
    if (have_exp) begin
      bad = 0;
      vectors++;
      if (out_de !== e_de) begin
        bad = 1;
        $display("FAIL %s out_de: actual %b expected %b (col %0d row %0d)", tag, out_de, e_de, m_col, m_row);
      end
      if (out_hs !== e_hs || out_vs !== e_vs || out_pix !== e_pix) begin
        bad = 1;
        $display("FAIL R1 hs/vs/pix: actual %b/%b/%h expected %b/%b/%h",
                 out_hs, out_vs, out_pix, e_hs, e_vs, e_pix);
      end
      if (bad) miscompares++;
    end
    in_de = de; in_hs = hs; in_vs = vs; in_pix = pix;
    wr_en = we; wr_addr = wa; wr_data = wd;
    c = (de && !m_de) ? 16'd0 : m_col;
    e_de = de && keep_px(c, m_row);
    e_hs = hs; e_vs = vs; e_pix = pix;
    if (de) m_col = c + 16'd1;
    if (vs && !m_vs) begin
      s_xs = {m_reg[1], m_reg[0]}; s_xe = {m_reg[3], m_reg[2]};
      s_ys = {m_reg[5], m_reg[4]}; s_ye = {m_reg[7], m_reg[6]};
      s_en = m_reg[8][0];
      m_row = 16'd0;
    end else if (!de && m_de) m_row = m_row + 16'd1;
    if (we && wa <= 4'd8) m_reg[wa] = (wa == 4'd8) ? {7'd0, wd[0]} : wd;
    m_de = de; m_vs = vs;
    have_exp = 1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    step(0, 0, 0, '0, 1, a, d);
  endtask

  task automatic set_win(input logic en, input logic [15:0] xs, input logic [15:0] xe,
                         input logic [15:0] ys, input logic [15:0] ye);
    wr(4'd0, xs[7:0]); wr(4'd1, xs[15:8]);
    wr(4'd2, xe[7:0]); wr(4'd3, xe[15:8]);
    wr(4'd4, ys[7:0]); wr(4'd5, ys[15:8]);
    wr(4'd6, ye[7:0]); wr(4'd7, ye[15:8]);
    wr(4'd8, {7'd0, en});
  endtask

  logic        p_en;
  logic [15:0] p_xs, p_xe, p_ys, p_ye;

  task automatic frame(input int hact, input int vact, input int hbl, input bit mid);
    for (int l = 0; l < 2; l++)
      for (int i = 0; i < hbl + hact; i++) step(0, i < 2, 1, '0, 0, '0, '0);
    for (int i = 0; i < hbl + hact; i++) step(0, i < 2, 0, '0, 0, '0, '0);
    for (int l = 0; l < vact; l++) begin
      for (int i = 0; i < hbl; i++) step(0, i < 2, 0, '0, 0, '0, '0);
      for (int i = 0; i < hact; i++) step(1, 0, 0, DW'($urandom), 0, '0, '0);
      if (mid && l == 0) set_win(p_en, p_xs, p_xe, p_ys, p_ye);
    end
    for (int i = 0; i < hbl; i++) step(0, i < 2, 0, '0, 0, '0, '0);
  endtask

  task automatic end_sim();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL R9 watchdog: actual hung expected finished");
      end_sim();
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 9; i++) m_reg[i] = '0;
    s_xs = '0; s_xe = '0; s_ys = '0; s_ye = '0; s_en = 0;
    m_col = '0; m_row = '0; m_de = 0; m_vs = 0;
    e_de = 0; e_hs = 0; e_vs = 0; e_pix = '0;
    // R2: outputs low while reset is held
    have_exp = 1;
    for (int i = 0; i < 3; i++) step(0, 0, 0, '0, 0, '0, '0);
    rst_n = 1'b1;
    // R3: reset default is bypass
    tag = "R3"; frame(10, 4, 6, 0);
    // R2: zeroed coordinates give the single pixel at (0,0)
    tag = "R2"; wr(4'd8, 8'h01); frame(10, 4, 6, 0);
    // R4: inclusive column bounds
    tag = "R4"; set_win(1, 3, 7, 0, 9); frame(12, 5, 6, 0);
    // R5: inclusive row bounds at the last column and row
    tag = "R5"; set_win(1, 0, 11, 4, 4); frame(12, 5, 6, 0);
    tag = "R5"; set_win(1, 11, 11, 1, 2); frame(12, 5, 6, 0);
    // R6: unused addresses change nothing; high bytes are decoded
    tag = "R6"; set_win(1, 2, 5, 1, 3);
    for (int a = 9; a < 16; a++) wr(4'(a), 8'hA5);
    frame(12, 5, 6, 0);
    tag = "R6"; set_win(1, 16'h0100, 16'h0100, 0, 3); frame(12, 5, 6, 0);
    // R8: inverted windows suppress the whole frame
    tag = "R8"; set_win(1, 6, 2, 0, 4); frame(12, 5, 6, 0);
    tag = "R8"; set_win(1, 0, 11, 3, 1); frame(12, 5, 6, 0);
    // R7: mid-frame write takes effect only at the next vsync
    tag = "R7"; set_win(1, 1, 4, 0, 2);
    p_en = 1; p_xs = 6; p_xe = 9; p_ys = 2; p_ye = 4;
    frame(12, 6, 6, 1);
    frame(12, 6, 6, 0);
    // R9: random frames and windows
    tag = "R9";
    for (int f = 0; f < 24; f++) begin
      int ha, va;
      ha = 6 + int'($urandom % 20);
      va = 2 + int'($urandom % 8);
      set_win(logic'($urandom % 4 != 0), 16'($urandom % (ha + 2)), 16'($urandom % (ha + 2)),
              16'($urandom % (va + 2)), 16'($urandom % (va + 2)));
      frame(ha, va, 4 + int'($urandom % 6), 0);
    end
    step(0, 0, 0, '0, 0, '0, '0);
    done = 1;
    end_sim();
  end
endmodule